// File: doc/BRIEF.md
# Keyboard Matrix and Sound Generator Port

This block sits on an 8-bit CPU I/O bus and serves a keyboard matrix and a slow sound generator. A write to the keyboard port stores a control byte. Its low nibble picks the keyboard row to drive. Three bits light LEDs on the card and the keyboard. The top bit chooses what appears on bit 0 of the keyboard read.

A read of the keyboard port returns the eight column lines of the driven row. The columns are inverted, so a pressed key reads as 1. When the select bit is set, bit 0 carries the sound generator's ready flag instead of column 0. Software can therefore poll the slow generator and scan the keyboard through one port.

A write to the sound port captures the byte and raises a write strobe toward the generator. The strobe stays high until the generator reports ready. It is high for at least one cycle.

Top module: `kbd_sound_port`

## Requirements
- R1: After reset, row 0 is driven (row_n = 10'b11_1111_1110), all three LEDs are off, bit 0 of a keyboard read shows column 0, snd_wr is 0 and snd_data is 0.
- R2: A write (io_wr=1) to address KBD_PORT (default 8'hC4) latches the data byte at the clock edge. Bits 3:0 are the row code, bit 4 drives led_caps, bit 5 drives led_fn, bit 6 drives led_card and bit 7 is the column-0 select. The outputs show the new values from the cycle after the write.
- R3: row_n is active-low one-hot. For row codes 0 to 9, row_n[code] is 0 and every other line is 1. For row codes 10 to 15, all ten lines are 1.
- R4: During a read (io_rd=1) of KBD_PORT, io_rdata[7:1] equals ~col_n[7:1] in the same cycle, so a pressed key (column line low) reads as 1.
- R5: During such a read, io_rdata[0] is ~col_n[0] when the select bit is 0 and snd_ready when the select bit is 1.
- R6: io_rdata is 8'h00 whenever io_rd is 0 or io_addr is not KBD_PORT.
- R7: A write to SND_PORT (default 8'hC5) loads snd_data with the data byte and sets snd_wr to 1 from the next cycle.
- R8: Once snd_wr is 1, it stays 1 through every clock edge at which snd_ready is 0. It clears at the first edge at which snd_ready is 1, unless a new sound write arrives at that same edge. As a result snd_wr lasts at least one cycle.
- R9: Writes to any address other than KBD_PORT and SND_PORT leave row_n, the LEDs, snd_wr and snd_data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| io_addr | input | 8 | I/O port address |
| io_wdata | input | 8 | Write data |
| io_wr | input | 1 | Write cycle qualifier |
| io_rd | input | 1 | Read cycle qualifier |
| io_rdata | output | 8 | Read data, zero when not selected |
| col_n | input | 8 | Keyboard column lines, active low |
| snd_ready | input | 1 | Sound generator ready flag |
| row_n | output | ROWS | Keyboard row drive, active low one-hot |
| led_caps | output | 1 | Caps LED |
| led_fn | output | 1 | Function LED |
| led_card | output | 1 | Card LED |
| snd_wr | output | 1 | Sound write strobe |
| snd_data | output | 8 | Byte to the sound generator |

## Verification
Several properties are checked on every cycle. The row drive must never have more than one low line. Out-of-range row codes must blank all rows. The read bus must be zero outside a keyboard read. The LED latch must follow each keyboard write, and the sound strobe must rise, hold and drop as the ready handshake requires.

The bench scenarios cover what depends on the stored select bit and on the history of writes. This includes the column-0 substitution, the inverted column read under random key patterns, and that foreign writes leave every output untouched. It also covers the one-cycle minimum of the strobe when the generator is already ready.

// File: rtl/kbd_sound_port.sv
module kbd_sound_port #(
  parameter logic [7:0] KBD_PORT = 8'hC4,
  parameter logic [7:0] SND_PORT = 8'hC5,
  parameter int         ROWS     = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [7:0]      io_addr,
  input  logic [7:0]      io_wdata,
  input  logic            io_wr,
  input  logic            io_rd,
  output logic [7:0]      io_rdata,
  input  logic [7:0]      col_n,
  input  logic            snd_ready,
  output logic [ROWS-1:0] row_n,
  output logic            led_caps,
  output logic            led_fn,
  output logic            led_card,
  output logic            snd_wr,
  output logic [7:0]      snd_data
);

  logic [7:0] ctl;
  logic       kbd_wr, snd_hit, kbd_rd;

  assign kbd_wr  = io_wr && (io_addr == KBD_PORT);
  assign snd_hit = io_wr && (io_addr == SND_PORT);
  assign kbd_rd  = io_rd && (io_addr == KBD_PORT);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      ctl <= '0;
    else if (kbd_wr) ctl <= io_wdata;

  for (genvar i = 0; i < ROWS; i++) begin : g_row
    assign row_n[i] = !(ctl[3:0] == 4'(i));
  end

  assign led_caps = ctl[4];
  assign led_fn   = ctl[5];
  assign led_card = ctl[6];

  logic [7:0] cols;
  assign cols     = {~col_n[7:1], ctl[7] ? snd_ready : ~col_n[0]};
  assign io_rdata = kbd_rd ? cols : 8'h00;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      snd_wr   <= 1'b0;
      snd_data <= '0;
    end else if (snd_hit) begin
      snd_wr   <= 1'b1;
      snd_data <= io_wdata;
    end else if (snd_wr && snd_ready) begin
      snd_wr   <= 1'b0;
    end

endmodule

module kbd_sound_port_chk #(
  parameter logic [7:0] KBD_PORT = 8'hC4,
  parameter logic [7:0] SND_PORT = 8'hC5,
  parameter int         ROWS     = 10
) (
  input logic            clk,
  input logic            rst_n,
  input logic [7:0]      io_addr,
  input logic [7:0]      io_wdata,
  input logic            io_wr,
  input logic            io_rd,
  input logic [7:0]      io_rdata,
  input logic            snd_ready,
  input logic [ROWS-1:0] row_n,
  input logic            led_caps,
  input logic            snd_wr,
  input logic [7:0]      snd_data
);

  // R3
  row_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~row_n));

  // R3
  row_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == KBD_PORT && int'(io_wdata[3:0]) >= ROWS) |=> (&row_n));

  // R2
  caps_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == KBD_PORT) |=> (led_caps == $past(io_wdata[4])));

  // R6
  rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_rd && io_addr == KBD_PORT) |-> (io_rdata == 8'h00));

  // R7
  snd_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == SND_PORT) |=> (snd_wr && snd_data == $past(io_wdata)));

  // R8
  snd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snd_wr && !snd_ready) |=> snd_wr);

  // R8
  snd_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snd_wr && snd_ready && !(io_wr && io_addr == SND_PORT)) |=> !snd_wr);

endmodule

bind kbd_sound_port kbd_sound_port_chk #(
  .KBD_PORT(KBD_PORT), .SND_PORT(SND_PORT), .ROWS(ROWS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
  .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata), .snd_ready(snd_ready),
  .row_n(row_n), .led_caps(led_caps), .snd_wr(snd_wr), .snd_data(snd_data)
);

// File: tb/kbd_sound_port_test.sv
module kbd_sound_port_test;
  localparam logic [7:0] KP = 8'hC4;
  localparam logic [7:0] SP = 8'hC5;

  logic clk = 0, rst_n = 0;
  logic [7:0] io_addr = 0, io_wdata = 0, col_n = 8'hFF;
  logic io_wr = 0, io_rd = 0, snd_ready = 1;
  logic [7:0] io_rdata, snd_data;
  logic [9:0] row_n;
  logic led_caps, led_fn, led_card, snd_wr;

  int checks = 0, errors = 0;
  logic [7:0] m_ctl = 0, m_snd = 0;

  always #5 clk = ~clk;

  kbd_sound_port uut (.*);

  function automatic logic [9:0] exp_rows(input logic [3:0] c);
    logic [9:0] r = 10'h3FF;
    if (c < 10) r[c] = 1'b0;
    return r;
  endfunction

  function automatic logic [7:0] exp_read(input logic [7:0] ctl, input logic [7:0] cn, input logic rdy);
    logic [7:0] v = ~cn;
    if (ctl[7]) v[0] = rdy;
    return v;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1;
    @(negedge clk); io_wr = 0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [7:0] r);
    @(negedge clk); io_addr = a; io_rd = 1;
    #1 r = io_rdata;
    @(negedge clk); io_rd = 0;
  endtask

  task automatic check_outs(input string req);
    chk(req, {22'd0, row_n}, {22'd0, exp_rows(m_ctl[3:0])});
    chk(req, {led_card, led_fn, led_caps}, m_ctl[6:4]);
    chk(req, {snd_wr, snd_data}, {1'b0, m_snd});
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] r;
    void'($urandom(32'h1234_5678));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check_outs("R1");
    chk("R1", {22'd0, row_n}, 32'h3FE);
    col_n = 8'b1111_1110;
    bus_read(KP, r);
    chk("R1 col0 select", r, 8'h01);

    // R3 every row code
    for (int c = 0; c < 16; c++) begin
      m_ctl = {4'b0101, 4'(c)};
      bus_write(KP, m_ctl);
      chk("R3", {22'd0, row_n}, {22'd0, exp_rows(4'(c))});
      chk("R2", {led_card, led_fn, led_caps}, m_ctl[6:4]);
    end

    // R5 directed select cases
    m_ctl = 8'h80; bus_write(KP, m_ctl);
    col_n = 8'hFF; snd_ready = 1;
    bus_read(KP, r); chk("R5 ready=1", r, 8'h01);
    col_n = 8'h00; snd_ready = 0;
    bus_read(KP, r); chk("R5 ready=0", r, 8'hFE);
    m_ctl = 8'h00; bus_write(KP, m_ctl);
    bus_read(KP, r); chk("R5 col0", r, 8'hFF);
    snd_ready = 1;

    // R7 / R8 strobe held while not ready
    snd_ready = 0;
    m_snd = 8'h9A; bus_write(SP, m_snd);
    chk("R7", {snd_wr, snd_data}, {1'b1, m_snd});
    repeat (3) begin
      @(negedge clk); chk("R8 hold", snd_wr, 1'b1);
    end
    snd_ready = 1;
    @(negedge clk); chk("R8 drop", snd_wr, 1'b0);
    // R8 minimum width with ready already high
    m_snd = 8'h3C; bus_write(SP, m_snd);
    chk("R8 min", {snd_wr, snd_data}, {1'b1, m_snd});
    @(negedge clk); chk("R8 min drop", snd_wr, 1'b0);

    // random mix
    for (int i = 0; i < 300; i++) begin
      int op = $urandom_range(0, 3);
      logic [7:0] a, d;
      d = 8'($urandom);
      col_n = 8'($urandom);
      snd_ready = 1'($urandom);
      do a = 8'($urandom); while (a == KP || a == SP);
      case (op)
        0: begin m_ctl = d; bus_write(KP, d); check_outs("R2"); end
        1: begin bus_read(KP, r); chk("R4 R5", r, exp_read(m_ctl, col_n, snd_ready)); end
        2: begin bus_read(a, r); chk("R6", r, 8'h00); end
        default: begin bus_write(a, d); check_outs("R9"); end
      endcase
    end
    @(negedge clk); io_rd = 0; #1 chk("R6 idle", io_rdata, 8'h00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule